// File: doc/BRIEF.md
# Fractional Multiply-Accumulate Datapath

This block is the arithmetic core of a 16-bit fixed-point signal processor. Two 16-bit operand registers, X and Y, are written from a shared data bus. A single-cycle multiplier treats both operands as two's-complement fractions and keeps a 24-bit product in a product register. A second path carries the data bus value, aligned to the top of a 24-bit word. Either value passes through a four-way shifter into a 24-bit adder/subtractor. That adder feeds a 24-bit accumulator and four status flags: negative, overflow, zero and carry.

A 3-bit opcode selects the operation each cycle. Two static controls shape the arithmetic. The first forces a right-by-three scale on any value taken from the product register, which lets long sums of products run without overflow. The second makes the adder clamp to the largest positive or negative value instead of wrapping. The accumulator is visible in full, and also as its upper 16 bits, which is the word a processor reads back onto its data bus. A multiply-accumulate adds the previous product to the accumulator and captures the new product on the same clock edge, so a stream of multiply-accumulates fills the pipeline one product per cycle.

Top module: `fmac_core`

## Requirements
- R1: After reset the accumulator, all four flags and the product register read zero; a pass of the product right after reset yields zero with only the zero flag set.
- R2: A multiply (opcode 4) stores bits 30 down to 7 of the signed 32-bit product X*Y in the product register, so the value is the fractional product truncated to 24 bits (0x4000*0x4000 gives 0x200000, 0x7FFF*0x7FFF gives 0x7FFE00).
- R3: The product of 0x8000 by 0x8000 is stored as 0x800000 (minus one).
- R4: A load (opcode 1) puts the data bus in accumulator bits 23:8 and clears bits 7:0, and it leaves the flags unchanged; the 16-bit accumulator output always shows accumulator bits 23:8.
- R5: The shift code acts on the selected adder source: 0 none, 1 arithmetic right by one, 2 arithmetic right by three, 3 left by one with a zero fill and the top bit lost.
- R6: While the scale control is high, a value taken from the product register is shifted right by three whatever the shift code; a value taken from the data bus still follows the shift code.
- R7: Add (opcode 2) and subtract (opcode 3) wrap modulo 2^24 when saturation is off. C is the carry out of bit 23, and for subtract it is the carry of acc + ~src + 1, so C=1 means no borrow. OV flags signed overflow.
- R8: With saturation on, an overflowing add, subtract or multiply-accumulate stores 0x7FFFFF if the accumulator was non-negative and 0x800000 if it was negative, and OV is still set.
- R9: A multiply-accumulate (opcode 5) adds the shifted old product-register value to the accumulator, ignoring the source select. On the same edge it writes X*Y into the product register.
- R10: N and Z follow the stored result after add, subtract, multiply-accumulate and pass. Pass (opcode 6) stores the shifted source and clears OV and C. Idle (opcodes 0 and 7) and multiply leave the accumulator and flags unchanged.
- R11: A high x_we or y_we for one cycle writes the data bus into X or Y, independent of the opcode.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| data_in | input | 16 | Data bus value for X, Y, load and the bus source |
| x_we | input | 1 | Write data_in into X |
| y_we | input | 1 | Write data_in into Y |
| op | input | 3 | Opcode: 0 idle, 1 load, 2 add, 3 sub, 4 multiply, 5 multiply-accumulate, 6 pass, 7 idle |
| src_sel | input | 1 | Adder source: 0 data bus (aligned high), 1 product register |
| shift_sel | input | 2 | Shift code for the adder source |
| scale3_en | input | 1 | Force right-by-three on product-register values |
| sat_en | input | 1 | Clamp on overflow instead of wrapping |
| acc_o | output | 24 | Full accumulator |
| acc_hi_o | output | 16 | Upper 16 bits of the accumulator |
| flag_n_o | output | 1 | Negative flag |
| flag_ov_o | output | 1 | Overflow flag |
| flag_z_o | output | 1 | Zero flag |
| flag_c_o | output | 1 | Carry flag |

## Verification
The hardest state to reach from the ports is a saturating overflow on a subtract, because the accumulator must hold a large negative value while the source has the opposite sign and a large magnitude. The stimulus loads 0x8000 through the load path and then subtracts a bus value. The same-edge behaviour of multiply-accumulate is also hidden, because the product register has no output. It is exposed by following two back-to-back multiply-accumulates, which use different X values, with a pass of the product register. That pass shows the product the second step captured, while the accumulator shows the sum of the older ones.

// File: rtl/fmac_pkg.sv
package fmac_pkg;

  typedef enum logic [2:0] {
    OP_IDLE = 3'd0,
    OP_LOAD = 3'd1,
    OP_ADD  = 3'd2,
    OP_SUB  = 3'd3,
    OP_MUL  = 3'd4,
    OP_MAC  = 3'd5,
    OP_PASS = 3'd6,
    OP_RSVD = 3'd7
  } fmac_op_e;

  typedef enum logic [1:0] {
    SH_NONE = 2'd0,
    SH_R1   = 2'd1,
    SH_R3   = 2'd2,
    SH_L1   = 2'd3
  } fmac_shift_e;

  typedef struct packed {
    logic n;
    logic ov;
    logic z;
    logic c;
  } fmac_flags_t;

endpackage

// File: rtl/fmac_mult.sv
module fmac_mult #(
  parameter int DW = 16,
  parameter int AW = 24
) (
  input  logic [DW-1:0] a_i,
  input  logic [DW-1:0] b_i,
  output logic [AW-1:0] prod_o
);
  localparam int PW = 2 * DW;
  localparam logic [DW-1:0] NEG_ONE_IN  = {1'b1, {(DW-1){1'b0}}};
  localparam logic [AW-1:0] NEG_ONE_OUT = {1'b1, {(AW-1){1'b0}}};

  logic signed [PW-1:0] a_ext;
  logic signed [PW-1:0] b_ext;
  logic signed [PW-1:0] full;
  logic                 both_min;
  logic [PW-AW-1:0]     unused_bits;

  always_comb begin
    a_ext    = {{DW{a_i[DW-1]}}, a_i};
    b_ext    = {{DW{b_i[DW-1]}}, b_i};
    full     = a_ext * b_ext;
    both_min = (a_i == NEG_ONE_IN) && (b_i == NEG_ONE_IN);
    // Drop the redundant sign bit, keep the next AW bits (fraction aligned).
    // The -1 x -1 case is pinned to -1 explicitly.
    prod_o   = both_min ? NEG_ONE_OUT : full[PW-2 -: AW];
  end

  assign unused_bits = {full[PW-1], full[PW-AW-2:0]};

endmodule

// File: rtl/fmac_shift.sv
module fmac_shift
  import fmac_pkg::*;
#(
  parameter int AW = 24
) (
  input  logic [AW-1:0] din_i,
  input  fmac_shift_e   mode_i,
  output logic [AW-1:0] dout_o
);
  logic sgn;

  always_comb begin
    sgn = din_i[AW-1];
    unique case (mode_i)
      SH_R1:   dout_o = {sgn, din_i[AW-1:1]};
      SH_R3:   dout_o = {{3{sgn}}, din_i[AW-1:3]};
      SH_L1:   dout_o = {din_i[AW-2:0], 1'b0};
      default: dout_o = din_i;
    endcase
  end

endmodule

// File: rtl/fmac_alu.sv
module fmac_alu
  import fmac_pkg::*;
#(
  parameter int AW = 24
) (
  input  logic [AW-1:0] acc_a_i,
  input  logic [AW-1:0] opnd_b_i,
  input  fmac_op_e      op_i,
  input  logic          sat_en_i,
  output logic [AW-1:0] res_o,
  output fmac_flags_t   flags_o
);
  localparam logic [AW-1:0] SAT_MAX = {1'b0, {(AW-1){1'b1}}};
  localparam logic [AW-1:0] SAT_MIN = {1'b1, {(AW-1){1'b0}}};

  logic          sub_mode;
  logic [AW-1:0] b_eff;
  logic [AW:0]   sum;
  logic [AW-1:0] raw;
  logic          ovf;

  always_comb begin
    sub_mode = (op_i == OP_SUB);
    b_eff    = sub_mode ? ~opnd_b_i : opnd_b_i;
    sum      = {1'b0, acc_a_i} + {1'b0, b_eff} + {{AW{1'b0}}, sub_mode};
    raw      = sum[AW-1:0];
    ovf      = (acc_a_i[AW-1] == b_eff[AW-1]) && (raw[AW-1] != acc_a_i[AW-1]);

    if (op_i == OP_PASS) begin
      res_o      = opnd_b_i;
      flags_o.ov = 1'b0;
      flags_o.c  = 1'b0;
    end else begin
      flags_o.ov = ovf;
      flags_o.c  = sum[AW];
      // On overflow the true result carries the accumulator's sign.
      if (sat_en_i && ovf) res_o = acc_a_i[AW-1] ? SAT_MIN : SAT_MAX;
      else                 res_o = raw;
    end
    flags_o.n = res_o[AW-1];
    flags_o.z = (res_o == '0);
  end

endmodule

// File: rtl/fmac_core.sv
module fmac_core
  import fmac_pkg::*;
#(
  parameter int DW = 16,
  parameter int AW = 24
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [15:0]   data_in,
  input  logic          x_we,
  input  logic          y_we,
  input  logic [2:0]    op,
  input  logic          src_sel,
  input  logic [1:0]    shift_sel,
  input  logic          scale3_en,
  input  logic          sat_en,
  output logic [23:0]   acc_o,
  output logic [15:0]   acc_hi_o,
  output logic          flag_n_o,
  output logic          flag_ov_o,
  output logic          flag_z_o,
  output logic          flag_c_o
);
  localparam int LOW_W = AW - DW;

  // Reset: asserted asynchronously, released on the clock.
  logic [1:0] rst_pipe;
  logic       rst_core_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe <= 2'b00;
    else        rst_pipe <= {rst_pipe[0], 1'b1};
  end
  assign rst_core_n = rst_pipe[1];

  // State
  logic [DW-1:0] x_q, y_q;
  logic [AW-1:0] p_q, acc_q;
  fmac_flags_t   flg_q;

  // Next-state and enables
  fmac_op_e      op_e;
  logic          x_en, y_en, p_en, acc_en, flg_en;
  logic          use_prod;
  logic [AW-1:0] bus_word, src_word, shifted, alu_res, acc_d, p_d;
  fmac_shift_e   eff_shift;
  fmac_flags_t   alu_flags;

  always_comb begin
    op_e      = fmac_op_e'(op);
    x_en      = x_we;
    y_en      = y_we;
    p_en      = (op_e == OP_MUL) || (op_e == OP_MAC);
    acc_en    = (op_e == OP_LOAD) || (op_e == OP_ADD) || (op_e == OP_SUB) ||
                (op_e == OP_MAC)  || (op_e == OP_PASS);
    flg_en    = (op_e == OP_ADD) || (op_e == OP_SUB) ||
                (op_e == OP_MAC) || (op_e == OP_PASS);
    bus_word  = {data_in, {LOW_W{1'b0}}};
    use_prod  = (op_e == OP_MAC) || src_sel;
    src_word  = use_prod ? p_q : bus_word;
    eff_shift = (scale3_en && use_prod) ? SH_R3 : fmac_shift_e'(shift_sel);
    acc_d     = (op_e == OP_LOAD) ? bus_word : alu_res;
  end

  fmac_mult #(.DW(DW), .AW(AW)) i_mult (
    .a_i   (x_q),
    .b_i   (y_q),
    .prod_o(p_d)
  );

  fmac_shift #(.AW(AW)) i_shift (
    .din_i (src_word),
    .mode_i(eff_shift),
    .dout_o(shifted)
  );

  fmac_alu #(.AW(AW)) i_alu (
    .acc_a_i (acc_q),
    .opnd_b_i(shifted),
    .op_i    (op_e),
    .sat_en_i(sat_en),
    .res_o   (alu_res),
    .flags_o (alu_flags)
  );

  // Registers
  always_ff @(posedge clk or negedge rst_core_n) begin
    if (!rst_core_n) begin
      x_q   <= '0;
      y_q   <= '0;
      p_q   <= '0;
      acc_q <= '0;
      flg_q <= '0;
    end else begin
      if (x_en)   x_q   <= data_in;
      if (y_en)   y_q   <= data_in;
      if (p_en)   p_q   <= p_d;
      if (acc_en) acc_q <= acc_d;
      if (flg_en) flg_q <= alu_flags;
    end
  end

  assign acc_o     = acc_q;
  assign acc_hi_o  = acc_q[AW-1 -: DW];
  assign flag_n_o  = flg_q.n;
  assign flag_ov_o = flg_q.ov;
  assign flag_z_o  = flg_q.z;
  assign flag_c_o  = flg_q.c;

endmodule

// File: rtl/fmac_chk.sv
module fmac_chk #(
  parameter int DW = 16,
  parameter int AW = 24
) (
  input logic          clk,
  input logic          rst_core_n,
  input logic [2:0]    op,
  input logic [DW-1:0] data_in,
  input logic          sat_en,
  input logic [AW-1:0] acc_o,
  input logic          flag_n_o,
  input logic          flag_ov_o,
  input logic          flag_z_o,
  input logic          flag_c_o
);
  localparam logic [AW-1:0] MAXV = {1'b0, {(AW-1){1'b1}}};
  localparam logic [AW-1:0] MINV = {1'b1, {(AW-1){1'b0}}};

  logic arith;
  logic [3:0] flg;
  assign arith = (op == 3'd2) || (op == 3'd3) || (op == 3'd5);
  assign flg   = {flag_n_o, flag_ov_o, flag_z_o, flag_c_o};

  p_load_value_r4: assert property (@(posedge clk) disable iff (!rst_core_n)
    (op == 3'd1) |=> (acc_o == {$past(data_in), {(AW-DW){1'b0}}}));

  p_load_flags_r4: assert property (@(posedge clk) disable iff (!rst_core_n)
    (op == 3'd1) |=> $stable(flg));

  p_idle_hold_r10: assert property (@(posedge clk) disable iff (!rst_core_n)
    (op == 3'd0 || op == 3'd7 || op == 3'd4) |=> ($stable(acc_o) && $stable(flg)));

  p_clamp_r8: assert property (@(posedge clk) disable iff (!rst_core_n)
    (sat_en && arith) |=> (!flag_ov_o || acc_o == MAXV || acc_o == MINV));

  p_zero_flag_r10: assert property (@(posedge clk) disable iff (!rst_core_n)
    (arith || op == 3'd6) |=> (flag_z_o == (acc_o == '0)));

  p_neg_flag_r10: assert property (@(posedge clk) disable iff (!rst_core_n)
    (arith || op == 3'd6) |=> (flag_n_o == acc_o[AW-1]));

  p_pass_clear_r10: assert property (@(posedge clk) disable iff (!rst_core_n)
    (op == 3'd6) |=> (!flag_ov_o && !flag_c_o));

endmodule

bind fmac_core fmac_chk #(.DW(DW), .AW(AW)) i_fmac_chk (
  .clk       (clk),
  .rst_core_n(rst_core_n),
  .op        (op),
  .data_in   (data_in),
  .sat_en    (sat_en),
  .acc_o     (acc_o),
  .flag_n_o  (flag_n_o),
  .flag_ov_o (flag_ov_o),
  .flag_z_o  (flag_z_o),
  .flag_c_o  (flag_c_o)
);

// File: tb/test_fmac_core.sv
`timescale 1ns/1ps
module test_fmac_core;
  logic        clk = 1'b0;
  logic        rst_n;
  logic [15:0] data_in;
  logic        x_we, y_we;
  logic [2:0]  op;
  logic        src_sel;
  logic [1:0]  shift_sel;
  logic        scale3_en, sat_en;
  logic [23:0] acc_o;
  logic [15:0] acc_hi_o;
  logic        flag_n_o, flag_ov_o, flag_z_o, flag_c_o;

  int n_run  = 0;
  int n_fail = 0;

  localparam logic [2:0] IDLE = 3'd0, LOAD = 3'd1, ADD = 3'd2, SUB = 3'd3,
                         MUL = 3'd4, MAC = 3'd5, PASS = 3'd6;

  always #2 clk = ~clk;

  fmac_core i_fmac_core (
    .clk(clk), .rst_n(rst_n), .data_in(data_in), .x_we(x_we), .y_we(y_we),
    .op(op), .src_sel(src_sel), .shift_sel(shift_sel), .scale3_en(scale3_en),
    .sat_en(sat_en), .acc_o(acc_o), .acc_hi_o(acc_hi_o), .flag_n_o(flag_n_o),
    .flag_ov_o(flag_ov_o), .flag_z_o(flag_z_o), .flag_c_o(flag_c_o)
  );

  function automatic logic [3:0] flags();
    return {flag_n_o, flag_ov_o, flag_z_o, flag_c_o};
  endfunction

  task automatic chk(input string req, input string what,
                     input logic [23:0] act, input logic [23:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  // Called at a falling edge; applies inputs, returns at the next falling edge.
  task automatic step(input logic [2:0] o, input logic [15:0] d,
                      input logic s, input logic [1:0] sh);
    op = o; data_in = d; src_sel = s; shift_sel = sh; x_we = 1'b0; y_we = 1'b0;
    @(negedge clk);
    op = IDLE;
  endtask

  task automatic wr_x(input logic [15:0] d);
    op = IDLE; data_in = d; x_we = 1'b1; y_we = 1'b0;
    @(negedge clk);
    x_we = 1'b0;
  endtask

  task automatic wr_y(input logic [15:0] d);
    op = IDLE; data_in = d; x_we = 1'b0; y_we = 1'b1;
    @(negedge clk);
    y_we = 1'b0;
  endtask

  task automatic mul_read(input string req, input logic [15:0] a,
                          input logic [15:0] b, input logic [23:0] exp);
    wr_x(a);
    wr_y(b);
    step(MUL, 16'h0, 1'b0, 2'd0);
    step(PASS, 16'h0, 1'b1, 2'd0);
    chk(req, "product", acc_o, exp);
  endtask

  task automatic t_reset();
    chk("R1", "acc after reset", acc_o, 24'h0);
    chk("R1", "flags after reset", {20'h0, flags()}, 24'h0);
    chk("R4", "hi word after reset", {8'h0, acc_hi_o}, 24'h0);
    step(PASS, 16'h0, 1'b1, 2'd0);
    chk("R1", "product after reset", acc_o, 24'h0);
    chk("R1", "flags on zero pass", {20'h0, flags()}, 24'h2);
  endtask

  task automatic t_load();
    step(LOAD, 16'h1234, 1'b0, 2'd0);
    chk("R4", "load value", acc_o, 24'h123400);
    chk("R4", "hi word", {8'h0, acc_hi_o}, 24'h1234);
    chk("R4", "flags kept", {20'h0, flags()}, 24'h2);
  endtask

  task automatic t_mult();
    mul_read("R2", 16'h4000, 16'h4000, 24'h200000);
    mul_read("R2", 16'hC000, 16'h4000, 24'hE00000);
    mul_read("R2", 16'h7FFF, 16'h7FFF, 24'h7FFE00);
    mul_read("R11", 16'h8000, 16'h7FFF, 24'h800100);
  endtask

  task automatic t_minus_one();
    mul_read("R3", 16'h8000, 16'h8000, 24'h800000);
    chk("R3", "flags", {20'h0, flags()}, 24'h8);
  endtask

  task automatic t_shift();
    step(PASS, 16'h8010, 1'b0, 2'd0);
    chk("R5", "no shift", acc_o, 24'h801000);
    step(PASS, 16'h8010, 1'b0, 2'd1);
    chk("R5", "right 1", acc_o, 24'hC00800);
    step(PASS, 16'h8010, 1'b0, 2'd2);
    chk("R5", "right 3", acc_o, 24'hF00200);
    step(PASS, 16'h8010, 1'b0, 2'd3);
    chk("R5", "left 1", acc_o, 24'h002000);
    chk("R10", "pass flags", {20'h0, flags()}, 24'h0);
    step(PASS, 16'h4008, 1'b0, 2'd2);
    chk("R5", "right 3 positive", acc_o, 24'h080100);
  endtask

  task automatic t_scale3();
    wr_x(16'h4000);
    wr_y(16'h4000);
    step(MUL, 16'h0, 1'b0, 2'd0);
    scale3_en = 1'b1;
    step(PASS, 16'h0, 1'b1, 2'd3);
    chk("R6", "forced right 3", acc_o, 24'h040000);
    step(PASS, 16'h1000, 1'b0, 2'd0);
    chk("R6", "bus unscaled", acc_o, 24'h100000);
    step(PASS, 16'h1000, 1'b0, 2'd1);
    chk("R6", "bus follows code", acc_o, 24'h080000);
    scale3_en = 1'b0;
  endtask

  task automatic t_addsub();
    step(LOAD, 16'h4000, 1'b0, 2'd0);
    step(ADD, 16'h2000, 1'b0, 2'd0);
    chk("R7", "add", acc_o, 24'h600000);
    chk("R7", "add flags", {20'h0, flags()}, 24'h0);
    step(ADD, 16'h3000, 1'b0, 2'd0);
    chk("R7", "add wrap", acc_o, 24'h900000);
    chk("R7", "wrap flags", {20'h0, flags()}, 24'hC);
    step(LOAD, 16'h1000, 1'b0, 2'd0);
    step(SUB, 16'h1000, 1'b0, 2'd0);
    chk("R7", "sub to zero", acc_o, 24'h0);
    chk("R10", "zero flags", {20'h0, flags()}, 24'h3);
    step(SUB, 16'h1000, 1'b0, 2'd0);
    chk("R7", "sub negative", acc_o, 24'hF00000);
    chk("R7", "borrow flags", {20'h0, flags()}, 24'h8);
    step(LOAD, 16'hF000, 1'b0, 2'd0);
    step(ADD, 16'h2000, 1'b0, 2'd0);
    chk("R7", "add carry", acc_o, 24'h100000);
    chk("R7", "carry flags", {20'h0, flags()}, 24'h1);
    step(LOAD, 16'h1000, 1'b0, 2'd0);
    step(ADD, 16'h8000, 1'b0, 2'd2);
    chk("R5", "shifted add", acc_o, 24'h000000);
    chk("R7", "shifted add flags", {20'h0, flags()}, 24'h3);
  endtask

  task automatic t_sat();
    sat_en = 1'b1;
    step(LOAD, 16'h6000, 1'b0, 2'd0);
    step(ADD, 16'h3000, 1'b0, 2'd0);
    chk("R8", "clamp max", acc_o, 24'h7FFFFF);
    chk("R8", "hi word", {8'h0, acc_hi_o}, 24'h7FFF);
    chk("R8", "max flags", {20'h0, flags()}, 24'h4);
    step(LOAD, 16'h8000, 1'b0, 2'd0);
    step(SUB, 16'h1000, 1'b0, 2'd0);
    chk("R8", "clamp min", acc_o, 24'h800000);
    chk("R8", "min flags", {20'h0, flags()}, 24'hD);
    step(LOAD, 16'h1000, 1'b0, 2'd0);
    step(ADD, 16'h1000, 1'b0, 2'd0);
    chk("R8", "no overflow", acc_o, 24'h200000);
    sat_en = 1'b0;
  endtask

  task automatic t_mac();
    wr_x(16'h4000);
    wr_y(16'h4000);
    step(LOAD, 16'h1000, 1'b0, 2'd0);
    step(MUL, 16'h0, 1'b0, 2'd0);
    chk("R10", "multiply keeps acc", acc_o, 24'h100000);
    wr_x(16'h2000);
    step(MAC, 16'h0, 1'b0, 2'd0);
    chk("R9", "first mac", acc_o, 24'h300000);
    step(MAC, 16'h0, 1'b0, 2'd0);
    chk("R9", "second mac uses new product", acc_o, 24'h400000);
    chk("R9", "mac flags", {20'h0, flags()}, 24'h0);
    step(PASS, 16'h0, 1'b1, 2'd0);
    chk("R9", "product captured with mac", acc_o, 24'h100000);
    step(IDLE, 16'hFFFF, 1'b0, 2'd0);
    chk("R10", "idle keeps acc", acc_o, 24'h100000);
  endtask

  initial begin
    #400000;
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    rst_n = 1'b0; data_in = '0; x_we = 1'b0; y_we = 1'b0; op = IDLE;
    src_sel = 1'b0; shift_sel = 2'd0; scale3_en = 1'b0; sat_en = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    t_reset();
    t_load();
    t_mult();
    t_minus_one();
    t_shift();
    t_scale3();
    t_addsub();
    t_sat();
    t_mac();
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

endmodule